// File: doc/BRIEF.md
# Triggered Logic Capture Buffer

This block is an on-chip logic analyser. It records an 8-bit probe bus into a 4096-entry sample memory. It takes one sample on every clock cycle, and capture starts on a rising edge of a trigger input. Software or a controller first sends an arm pulse. The block then waits for the trigger to go from low to high. It records exactly one buffer's worth of consecutive samples and then stops, raising a full flag.

The finished trace is read out as a byte stream for a burst transmitter. A replay pulse starts the stream at the oldest sample. The stream then advances one byte for each ready/valid handshake with the consumer and marks the final byte. A new arm pulse abandons any readout in progress and prepares the next capture.

Top module: `trig_capture_buffer`

## Requirements
- R1: After reset, `armed_o`, `capturing_o`, `full_o` and `out_valid_o` are all 0.
- R2: An arm pulse sets `armed_o`, clears `full_o` and drops `out_valid_o`, all on the next cycle. This applies in any state. An arm pulse takes priority over a trigger edge or a replay in the same cycle.
- R3: While the block is not armed, trigger activity has no effect: `capturing_o` stays 0 and the stored trace is unchanged.
- R4: Capture starts only in a cycle where the block is armed, `trig_i` is 1 and `trig_i` was 0 in the previous cycle. A trigger level already high when arming does not start capture until it falls and rises again.
- R5: The probe value present in the trigger-edge cycle is stored at address 0. Each following cycle stores the current probe value at the next address.
- R6: Exactly 4096 samples are stored. `full_o` rises, and `capturing_o` falls, on the clock edge that writes address 4095. After that, probe and trigger changes leave the trace unchanged.
- R7: A replay pulse is acted on only while `full_o` is 1. One cycle after it, `out_valid_o` is 1 and `out_data_o` holds the sample at address 0.
- R8: Each cycle where `out_valid_o` and `out_ready_i` are both 1 advances the stream by one address. While `out_ready_i` is 0, the byte on `out_data_o` is held.
- R9: `out_last_o` is 1 exactly while the byte at address 4095 is offered. After that byte's handshake, `out_valid_o` returns to 0.
- R10: A replay pulse during readout restarts the stream at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, also the sample clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Arm pulse: reset capture, await trigger |
| trig_i | input | 1 | Trigger source, rising-edge sensitive |
| probe_i | input | 8 | Probe bus sampled each cycle |
| replay_i | input | 1 | Start streaming the trace from address 0 |
| out_ready_i | input | 1 | Consumer ready |
| out_valid_o | output | 1 | Stream byte valid |
| out_data_o | output | 8 | Stream byte |
| out_last_o | output | 1 | Final byte of the trace |
| armed_o | output | 1 | Waiting for a trigger edge |
| capturing_o | output | 1 | Recording samples |
| full_o | output | 1 | Trace complete |

## Verification
The assertions assume that `arm_i` and `replay_i` are single-cycle pulses. They also assume that `out_ready_i` is a plain level, with no need to stay high once the consumer has asserted it. The properties are written so that the stall-hold and last-byte checks are waived in any cycle that carries a pulse. The stimulus drives all inputs on the falling edge. It mixes random probe bytes, random trigger toggles and random ready patterns from a fixed seed. It adds directed cases: a trigger held high across arming, a trigger edge coinciding with an arm pulse, a replay before the trace is full, and arming in the middle of a readout.

// File: rtl/trig_capture_buffer.sv
module trig_capture_buffer #(
  parameter int SW    = 8,
  parameter int DEPTH = 4096
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          trig_i,
  input  logic [SW-1:0] probe_i,
  input  logic          replay_i,
  input  logic          out_ready_i,
  output logic          out_valid_o,
  output logic [SW-1:0] out_data_o,
  output logic          out_last_o,
  output logic          armed_o,
  output logic          capturing_o,
  output logic          full_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST_W = AW'(DEPTH - 1);
  localparam logic [AW:0]   END_R  = (AW + 1)'(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_CAPT, S_FULL} st_t;

  st_t           st;
  logic [AW-1:0] wptr;
  logic [AW:0]   rptr;
  logic          trig_q, vld;
  logic [SW-1:0] rdat;
  logic [SW-1:0] mem [DEPTH];

  wire edge_hit = trig_i & ~trig_q;
  wire wr_en    = ~arm_i & ((st == S_ARMED & edge_hit) | st == S_CAPT);
  wire shake    = vld & out_ready_i;

  assign armed_o     = (st == S_ARMED);
  assign capturing_o = (st == S_CAPT);
  assign full_o      = (st == S_FULL);
  assign out_valid_o = vld;
  assign out_data_o  = rdat;
  assign out_last_o  = vld & (rptr == END_R);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st     <= S_IDLE;
      wptr   <= '0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= trig_i;
      if (arm_i) begin
        st   <= S_ARMED;
        wptr <= '0;
      end else begin
        case (st)
          S_ARMED: if (edge_hit) begin
            st   <= S_CAPT;
            wptr <= wptr + 1'b1;
          end
          S_CAPT: begin
            wptr <= wptr + 1'b1;
            if (wptr == LAST_W) st <= S_FULL;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) mem[wptr] <= probe_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      vld  <= 1'b0;
      rptr <= '0;
      rdat <= '0;
    end else if (arm_i) begin
      vld <= 1'b0;
    end else if (replay_i && st == S_FULL) begin
      rdat <= mem[0];
      rptr <= (AW + 1)'(1);
      vld  <= 1'b1;
    end else if (shake) begin
      if (rptr == END_R) begin
        vld <= 1'b0;
      end else begin
        rdat <= mem[rptr[AW-1:0]];
        rptr <= rptr + 1'b1;
      end
    end
  end

  assert_arm_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> armed_o && !full_o && !out_valid_o);

  assert_idle_ignores_trig_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_o && !capturing_o && !arm_i) |=> !capturing_o);

  assert_capture_needs_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && !arm_i && !(trig_i && !trig_q)) |=> !capturing_o);

  assert_full_after_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(capturing_o));

  assert_stream_needs_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> full_o);

  assert_stall_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !arm_i && !replay_i) |=> out_valid_o && $stable(out_data_o));

  assert_last_ends_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_last_o && out_ready_i && !arm_i && !replay_i) |=> !out_valid_o);
endmodule

// File: tb/tb_trig_capture_buffer.sv
module tb_trig_capture_buffer;
  localparam int N = 4096;

  logic clk = 0, rst_n = 0;
  logic arm = 0, trig = 0, replay = 0, rdy = 0;
  logic [7:0] probe = 0;
  logic vld, last, armed, capt, full;
  logic [7:0] dat;
  logic [7:0] exp_buf [N];
  int tests = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  trig_capture_buffer dut (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .trig_i(trig), .probe_i(probe),
    .replay_i(replay), .out_ready_i(rdy), .out_valid_o(vld), .out_data_o(dat),
    .out_last_o(last), .armed_o(armed), .capturing_o(capt), .full_o(full));

  function automatic logic [7:0] pat(input int mode, input int i);
    if (mode == 0) return 8'($urandom);
    return 8'(i ^ (i >> 8) ^ 8'h5A);
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int ex);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, ex);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse_arm();
    arm = 1; tick(); arm = 0;
  endtask

  // Trigger edge at the current negedge, then 4095 more samples.
  task automatic capture(input int mode);
    trig = 1; probe = pat(mode, 0); exp_buf[0] = probe;
    for (int i = 1; i < N; i++) begin
      tick();
      if (i == 1) check(capt === 1, "R4 capture started", capt, 1);
      trig = 1'($urandom);
      probe = pat(mode, i); exp_buf[i] = probe;
      if (i == N - 1) check(full === 0, "R6 not full before last", full, 0);
    end
    tick();
    check(full === 1 && capt === 0, "R6 full after 4096", full, 1);
    for (int i = 0; i < 20; i++) begin
      trig = ~trig; probe = 8'($urandom); tick();
    end
  endtask

  // Reads n bytes starting from address start, random ready.
  task automatic read_bytes(input int start, input int n);
    int k = start;
    while (k < start + n) begin
      rdy = 1'($urandom);
      if (vld && rdy) begin
        check(dat === exp_buf[k], "R5 R8 stream byte", dat, exp_buf[k]);
        check(last === (k == N - 1), "R9 last flag", last, k == N - 1);
        k++;
      end else if (vld) begin
        logic [7:0] held = dat;
        tick();
        check(vld === 1 && dat === held, "R8 stall hold", dat, held);
        continue;
      end
      tick();
    end
    rdy = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) tick();
    rst_n = 1; tick();
    check(!armed && !capt && !full && !vld, "R1 reset state", {armed, capt, full, vld}, 0);

    repeat (5) begin trig = ~trig; tick(); end
    trig = 0; tick(); trig = 1; tick();
    check(capt === 0 && armed === 0, "R3 trigger ignored unarmed", capt, 0);
    replay = 1; tick(); replay = 0; tick();
    check(vld === 0, "R7 replay ignored when not full", vld, 0);

    trig = 1; pulse_arm();
    check(armed === 1 && full === 0, "R2 armed after pulse", armed, 1);
    repeat (6) tick();
    check(capt === 0, "R4 held level no trigger", capt, 0);
    trig = 0; tick();
    trig = 1; arm = 1; tick(); arm = 0;
    check(armed === 1 && capt === 0, "R2 arm beats edge", capt, 0);
    trig = 0; repeat (3) tick();
    capture(0);

    replay = 1; tick(); replay = 0;
    check(vld === 1 && dat === exp_buf[0], "R7 first byte addr 0", dat, exp_buf[0]);
    read_bytes(0, N);
    tick();
    check(vld === 0, "R9 valid drops after last", vld, 0);

    replay = 1; tick(); replay = 0;
    read_bytes(0, 300);
    replay = 1; tick(); replay = 0;
    check(dat === exp_buf[0], "R10 restart at 0", dat, exp_buf[0]);
    read_bytes(0, 50);

    pulse_arm();
    check(vld === 0 && full === 0 && armed === 1, "R2 arm aborts readout", vld, 0);
    trig = 0; repeat (4) tick();
    capture(1);
    replay = 1; tick(); replay = 0;
    read_bytes(0, N);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end
endmodule